// File: doc/BRIEF.md
# Speculative Cache Line State Tracker

This block holds the tag and line-state array of a small set-associative first-level data cache in which two instruction streams run at once: an independent stream that runs ahead of outstanding load misses, and a dependent stream that re-executes the work that waited on those misses. Besides the ordinary committed state, every line may be marked as written speculatively by either stream. A lookup is classified as hit, miss, poisoned or stalled according to the requesting stream and the states of the matching ways. Stores update line states, and misses claim a victim way.

When dependent execution has finished, one command discards every line written by the independent stream and another promotes every line written by the dependent stream to committed. Either command completes in a single cycle. Data storage, refill from the next level and coherence traffic are handled elsewhere. A line that a load miss claims is recorded as committed, on the assumption that a refill will follow.

Top module: `spec_line_tracker`

## Requirements
- R1: After reset every line is invalid, so no lookup hits, and all response outputs are 0.
- R2: A lookup presented with req_valid=1 while neither bulk command is high gets its response in the next cycle with rsp_valid=1. Thread encoding is 0 for independent and 1 for dependent. Op encoding is 0 for load and 1 for store. The line address is {tag[7:0], set[3:0]}.
- R3: A load that misses claims a way as committed, and a later load of the same line by either thread hits that way.
- R4: An independent store that hits a committed line marks it speculative-independent. A store that hits a line already in its own thread's speculative state leaves the state unchanged.
- R5: An independent load hits a speculative-independent way first. Failing that, it hits a committed way.
- R6: An independent store whose only match is a speculative-dependent line misses, and a different way is claimed as speculative-independent.
- R7: An independent load that matches no speculative-independent way but does match a speculative-dependent way gives rsp_poison=1, rsp_hit=0 and that way in rsp_way, and claims no way.
- R8: A dependent store marks the line speculative-dependent. It hits a committed line in place, or it claims a way on a miss. A dependent load then hits that way.
- R9: A dependent load matching only a speculative-independent line misses.
- R10: The flush command turns every speculative-independent line invalid, and the commit command turns every speculative-dependent line committed. Each takes one cycle, and both may be given together.
- R11: A lookup issued in the same cycle as either bulk command is dropped. It gives no response and changes no state.
- R12: Victim choice takes the lowest-numbered invalid way. If there is none, it takes the first committed way at or after the set's round-robin pointer, and the pointer then moves past the chosen way. A speculative line is never chosen.
- R13: A miss in a set whose ways are all speculative gives rsp_stall=1 and rsp_hit=0, and leaves the set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_thread | input | 1 | 0 = independent, 1 = dependent |
| req_store | input | 1 | 0 = load, 1 = store |
| req_line | input | 12 | Line address {tag, set} |
| bulk_commit | input | 1 | Promote all speculative-dependent lines to committed |
| bulk_flush | input | 1 | Invalidate all speculative-independent lines |
| rsp_valid | output | 1 | Response for last cycle's lookup |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 2 | Way hit, poisoned or claimed |
| rsp_poison | output | 1 | Independent load must become dependent |
| rsp_stall | output | 1 | Miss with no eligible victim |

## Verification
The hardest situation to reach from the ports is a set that holds the same tag in two ways with different states, and then a bulk command that resolves both copies at once. The bench builds it with a chain of lookups in one set. An independent store first turns a committed line speculative-independent. A dependent load to the same line then misses and claims a second way. A dependent store next converts that second way to speculative-dependent. Follow-up loads from both threads, before and after the combined bulk command, show which copy each thread sees.

// File: rtl/spt_pkg.sv
package spt_pkg;
    typedef enum logic [1:0] {
        LN_INV  = 2'd0,
        LN_COM  = 2'd1,
        LN_SIND = 2'd2,
        LN_SDEP = 2'd3
    } line_st_e;
endpackage

// File: rtl/spt_first.sv
// Lowest-index set bit finder.
module spt_first #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/spt_match.sv
// Per-way tag compare split by line state.
module spt_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [WAYS-1:0][1:0]       st,
    input  logic [TAG_W-1:0]           tag,
    output logic [WAYS-1:0]            m_inv,
    output logic [WAYS-1:0]            m_com,
    output logic [WAYS-1:0]            m_sind,
    output logic [WAYS-1:0]            m_sdep
);
    import spt_pkg::*;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic eq;
        assign eq        = (tags[w] == tag);
        assign m_inv[w]  = (st[w] == LN_INV);
        assign m_com[w]  = eq && (st[w] == LN_COM);
        assign m_sind[w] = eq && (st[w] == LN_SIND);
        assign m_sdep[w] = eq && (st[w] == LN_SDEP);
    end
endmodule

// File: rtl/spt_victim.sv
// Victim choice: invalid ways first, then committed ways from the pointer on.
module spt_victim #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]  inv,
    input  logic [WAYS-1:0]  com,
    input  logic [WAY_W-1:0] ptr,
    output logic             found,
    output logic             from_rr,
    output logic [WAY_W-1:0] way
);
    logic [WAYS-1:0]  rot;
    logic             inv_found;
    logic             rr_found;
    logic [WAY_W-1:0] inv_idx;
    logic [WAY_W-1:0] rr_idx;

    always_comb begin
        for (int i = 0; i < WAYS; i++) begin
            rot[i] = com[WAY_W'(i) + ptr];
        end
    end

    spt_first #(.N(WAYS), .IW(WAY_W)) u_inv (.vec(inv), .found(inv_found), .idx(inv_idx));
    spt_first #(.N(WAYS), .IW(WAY_W)) u_rr  (.vec(rot), .found(rr_found),  .idx(rr_idx));

    always_comb begin
        found   = inv_found || rr_found;
        from_rr = !inv_found && rr_found;
        way     = inv_found ? inv_idx : (rr_idx + ptr);
    end
endmodule

// File: rtl/spec_line_tracker.sv
module spec_line_tracker #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int TAG_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic                              req_thread,
    input  logic                              req_store,
    input  logic [TAG_W+$clog2(SETS)-1:0]     req_line,
    input  logic                              bulk_commit,
    input  logic                              bulk_flush,
    output logic                              rsp_valid,
    output logic                              rsp_hit,
    output logic [$clog2(WAYS)-1:0]           rsp_way,
    output logic                              rsp_poison,
    output logic                              rsp_stall
);
    import spt_pkg::*;

    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int CNT_W = $clog2(SETS * WAYS + 1);

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic [SETS-1:0][WAYS-1:0][1:0]       st;
        logic [SETS-1:0][WAY_W-1:0]           ptr;
        logic                                 rsp_valid;
        logic                                 rsp_hit;
        logic [WAY_W-1:0]                     rsp_way;
        logic                                 rsp_poison;
        logic                                 rsp_stall;
    } trk_t;

    trk_t q, d;

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic             bulk_any;
    logic [1:0]       own_st;

    assign idx      = req_line[IDX_W-1:0];
    assign tag      = req_line[IDX_W+TAG_W-1:IDX_W];
    assign bulk_any = bulk_commit || bulk_flush;
    assign own_st   = req_thread ? LN_SDEP : LN_SIND;

    logic [WAYS-1:0] m_inv, m_com, m_sind, m_sdep, m_own;

    spt_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .tags   (q.tag[idx]),
        .st     (q.st[idx]),
        .tag    (tag),
        .m_inv  (m_inv),
        .m_com  (m_com),
        .m_sind (m_sind),
        .m_sdep (m_sdep)
    );

    assign m_own = req_thread ? m_sdep : m_sind;

    logic             own_f, com_f, sdep_f;
    logic [WAY_W-1:0] own_w, com_w, sdep_w;

    spt_first #(.N(WAYS), .IW(WAY_W)) u_own  (.vec(m_own),  .found(own_f),  .idx(own_w));
    spt_first #(.N(WAYS), .IW(WAY_W)) u_com  (.vec(m_com),  .found(com_f),  .idx(com_w));
    spt_first #(.N(WAYS), .IW(WAY_W)) u_sdep (.vec(m_sdep), .found(sdep_f), .idx(sdep_w));

    logic [WAYS-1:0]  com_any;
    logic             vic_f, vic_rr;
    logic [WAY_W-1:0] vic_w;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            com_any[w] = (q.st[idx][w] == LN_COM);
        end
    end

    spt_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .inv     (m_inv),
        .com     (com_any),
        .ptr     (q.ptr[idx]),
        .found   (vic_f),
        .from_rr (vic_rr),
        .way     (vic_w)
    );

    always_comb begin
        d            = q;
        d.rsp_valid  = 1'b0;
        d.rsp_hit    = 1'b0;
        d.rsp_way    = '0;
        d.rsp_poison = 1'b0;
        d.rsp_stall  = 1'b0;
        if (bulk_any) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (bulk_commit && q.st[s][w] == LN_SDEP) d.st[s][w] = LN_COM;
                    if (bulk_flush  && q.st[s][w] == LN_SIND) d.st[s][w] = LN_INV;
                end
            end
        end else if (req_valid) begin
            d.rsp_valid = 1'b1;
            if (own_f) begin
                d.rsp_hit = 1'b1;
                d.rsp_way = own_w;
            end else if (!req_thread && !req_store && sdep_f) begin
                d.rsp_poison = 1'b1;
                d.rsp_way    = sdep_w;
            end else if (com_f) begin
                d.rsp_hit = 1'b1;
                d.rsp_way = com_w;
                if (req_store) d.st[idx][com_w] = own_st;
            end else if (vic_f) begin
                d.rsp_way          = vic_w;
                d.tag[idx][vic_w]  = tag;
                d.st[idx][vic_w]   = req_store ? own_st : LN_COM;
                if (vic_rr) d.ptr[idx] = vic_w + 1'b1;
            end else begin
                d.rsp_stall = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_valid  = q.rsp_valid;
    assign rsp_hit    = q.rsp_hit;
    assign rsp_way    = q.rsp_way;
    assign rsp_poison = q.rsp_poison;
    assign rsp_stall  = q.rsp_stall;

    // Count of dependent-speculative lines, observed after a commit.
    logic [CNT_W-1:0] sdep_cnt;
    always_comb begin
        sdep_cnt = '0;
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                if (q.st[s][w] == LN_SDEP) sdep_cnt = sdep_cnt + 1'b1;
            end
        end
    end

    p_resp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !bulk_any) |=> rsp_valid);

    p_bulk_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bulk_any |=> !rsp_valid);

    p_commit_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bulk_commit |=> (sdep_cnt == '0));

    p_poison_indep_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_thread || req_store)) |=> !rsp_poison);

    p_stall_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_stall |-> (!rsp_hit && !rsp_poison && rsp_valid));
endmodule

// File: tb/spec_line_tracker_tb.sv
module spec_line_tracker_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_thread = 1'b0;
    logic        req_store = 1'b0;
    logic [11:0] req_line = '0;
    logic        bulk_commit = 1'b0;
    logic        bulk_flush = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_poison, rsp_stall;
    logic [1:0]  rsp_way;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spec_line_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_thread(req_thread),
        .req_store(req_store), .req_line(req_line), .bulk_commit(bulk_commit),
        .bulk_flush(bulk_flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_way(rsp_way), .rsp_poison(rsp_poison), .rsp_stall(rsp_stall)
    );

    function automatic logic [11:0] ln(input logic [7:0] t, input logic [3:0] s);
        return {t, s};
    endfunction

    task automatic check(input string req, input logic [5:0] exp);
        logic [5:0] act;
        act = {rsp_valid, rsp_hit, rsp_way, rsp_poison, rsp_stall};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {valid,hit,way,poison,stall} actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One lookup; response sampled at the falling edge after the capturing edge.
    task automatic lookup(input logic thr, input logic st, input logic [11:0] a,
                          input logic hit, input logic [1:0] way, input logic poi,
                          input logic stl, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_thread = thr; req_store = st; req_line = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {1'b1, hit, way, poi, stl});
    endtask

    task automatic bulk(input logic c, input logic f, input logic with_req, input logic [11:0] a);
        @(negedge clk);
        bulk_commit = c; bulk_flush = f;
        req_valid = with_req; req_thread = 1'b0; req_store = 1'b0; req_line = a;
        @(posedge clk);
        @(negedge clk);
        bulk_commit = 1'b0; bulk_flush = 1'b0; req_valid = 1'b0;
        check("R11 bulk cycle gives no response", 6'b000000);
    endtask

    task automatic t_reset;
        check("R1 reset outputs", 6'b000000);
        lookup(0, 0, ln(8'h11, 1), 0, 0, 0, 0, "R1 R12 first load misses into way0");
        lookup(0, 0, ln(8'h11, 1), 1, 0, 0, 0, "R3 R2 reload hits way0");
    endtask

    task automatic t_indep_store;
        lookup(0, 1, ln(8'h11, 1), 1, 0, 0, 0, "R4 indep store hits committed");
        lookup(1, 0, ln(8'h11, 1), 0, 1, 0, 0, "R9 dep load on spec-ind misses to way1");
        lookup(0, 0, ln(8'h11, 1), 1, 0, 0, 0, "R5 indep load prefers spec-ind way0");
        lookup(1, 0, ln(8'h11, 1), 1, 1, 0, 0, "R3 dep load hits committed way1");
    endtask

    task automatic t_dep_store;
        lookup(1, 1, ln(8'h11, 1), 1, 1, 0, 0, "R8 dep store hits committed way1");
        lookup(1, 0, ln(8'h11, 1), 1, 1, 0, 0, "R8 dep load hits spec-dep way1");
        lookup(0, 1, ln(8'h11, 1), 1, 0, 0, 0, "R4 indep store on own spec line hits");
    endtask

    task automatic t_poison;
        lookup(0, 0, ln(8'h22, 2), 0, 0, 0, 0, "R3 load miss set2");
        lookup(1, 1, ln(8'h22, 2), 1, 0, 0, 0, "R8 dep store converts way0");
        lookup(0, 0, ln(8'h22, 2), 0, 0, 1, 0, "R7 indep load poisoned");
        lookup(0, 0, ln(8'h22, 2), 0, 0, 1, 0, "R7 poison claimed no way");
        lookup(0, 1, ln(8'h22, 2), 0, 1, 0, 0, "R6 indep store on spec-dep allocs way1");
        lookup(0, 0, ln(8'h22, 2), 1, 1, 0, 0, "R6 R5 indep load hits new way1");
    endtask

    task automatic t_bulk_both;
        bulk(1, 1, 1, ln(8'h33, 3));
        lookup(0, 0, ln(8'h11, 1), 1, 1, 0, 0, "R10 set1 way1 committed");
        lookup(1, 0, ln(8'h11, 1), 1, 1, 0, 0, "R10 dep sees committed way1");
        lookup(0, 0, ln(8'h22, 2), 1, 0, 0, 0, "R10 set2 way0 committed, no poison");
        lookup(0, 0, ln(8'h33, 3), 0, 0, 0, 0, "R11 dropped lookup left set3 empty");
    endtask

    task automatic t_bulk_separate;
        lookup(1, 1, ln(8'h44, 4), 0, 0, 0, 0, "R8 dep store miss claims way0");
        lookup(0, 1, ln(8'h45, 4), 0, 1, 0, 0, "R4 indep store miss claims way1");
        bulk(0, 1, 0, '0);
        lookup(0, 0, ln(8'h44, 4), 0, 0, 1, 0, "R10 flush keeps spec-dep line");
        lookup(0, 0, ln(8'h45, 4), 0, 1, 0, 0, "R10 flush invalidated spec-ind way1");
        bulk(1, 0, 0, '0);
        lookup(0, 0, ln(8'h44, 4), 1, 0, 0, 0, "R10 commit made way0 committed");
    endtask

    task automatic t_round_robin;
        for (int i = 0; i < 4; i++)
            lookup(0, 0, ln(8'h50 + 8'(i), 5), 0, 2'(i), 0, 0, "R12 invalid ways fill in order");
        lookup(0, 0, ln(8'h54, 5), 0, 0, 0, 0, "R12 pointer picks way0");
        lookup(0, 0, ln(8'h55, 5), 0, 1, 0, 0, "R12 pointer advanced to way1");
        lookup(0, 0, ln(8'h50, 5), 0, 2, 0, 0, "R12 evicted tag refills way2");
    endtask

    task automatic t_stall;
        for (int i = 0; i < 4; i++)
            lookup(0, 1, ln(8'h60 + 8'(i), 6), 0, 2'(i), 0, 0, "R4 spec-ind fills set6");
        lookup(0, 1, ln(8'h64, 6), 0, 0, 0, 1, "R13 indep store stalls");
        lookup(1, 1, ln(8'h64, 6), 0, 0, 0, 1, "R13 dep store stalls");
        lookup(1, 0, ln(8'h61, 6), 0, 0, 0, 1, "R9 R13 dep load on spec-ind misses and stalls");
        lookup(0, 0, ln(8'h60, 6), 1, 0, 0, 0, "R13 set unchanged after stalls");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_indep_store();
        t_dep_store();
        t_poison();
        t_bulk_both();
        t_bulk_separate();
        t_round_robin();
        t_stall();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule